// File: doc/BRIEF.md
# Interleaved Host-to-Device Address Decoder

This block takes a host-side address offset that falls inside an interleaved memory region, together with an encoded way count and an encoded granularity. It returns two things: which member of the interleave set owns the address, and the offset inside that member's local address space. A request starts with a one-cycle `start` pulse. The result appears with a one-cycle `done` pulse and stays on the outputs until the next accepted request.

Power-of-two way counts are decoded by slicing bits, and the result is ready two cycles after `start`. Way counts of 3, 6 and 12 need a division by three. A radix-2 restoring divider handles this over a fixed number of steps. Its quotient gives the upper part of the device offset. Its remainder, joined with the low way-select bits, gives the position. An encoding that does not decode to a legal value raises `errFlag` and drives every result bit to one.

Top module: `ilv_addr_decode`

## Requirements
- R1: A synchronous active-high `rst` clears `busy`, `done` and `errFlag`.
- R2: The way code decodes as follows: 0 to 4 give 1, 2, 4, 8 and 16 ways, and 8, 9 and 10 give 3, 6 and 12 ways. Any other way code sets `errFlag`, with `position` and `devOff` all ones.
- R3: The granularity code g is legal from 0 to 6, which means 256 bytes shifted left by g. Any other value sets `errFlag`, with `position` and `devOff` all ones. A legal request clears `errFlag`.
- R4: For a legal request, `devOff[g+7:0]` equals `hostOff[g+7:0]`.
- R5: For way codes w from 0 to 4, `position` is `hostOff[g+8+w-1 : g+8]`. When w is 0, `position` is 0.
- R6: For way codes w from 0 to 4, the upper part of `devOff` is `hostOff` with bits [g+w+7:0] cleared, then shifted right by w.
- R7: For way codes w from 8 to 10, `position` is `(hostOff >> (g+8))` modulo the way count.
- R8: For way codes w from 8 to 10, the upper part of `devOff` is `((hostOff >> (g+w)) / 3) << (g+8)`.
- R9: `done` is high for exactly one cycle. For a bit-sliced or illegal request, it is high in the second cycle after the cycle that presents `start`. For a division request, it is high in the cycle 2+DIV_STEPS cycles after that cycle (DIV_STEPS is 52 by default).
- R10: While `busy` is high, `start` and any changes to the inputs have no effect. The result reflects the accepted request, and no extra `done` follows.
- R11: `position`, `devOff` and `errFlag` hold their values from `done` until the next accepted request, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, sampled when idle |
| hostOff | input | OFF_W | Host-side offset within the region |
| eiwCode | input | EIW_W | Encoded way count |
| eigCode | input | EIG_W | Encoded granularity |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle result strobe |
| errFlag | output | 1 | Last request had an illegal encoding |
| position | output | POS_W | Member index within the interleave set |
| devOff | output | OFF_W | Device-local offset |

## Verification
The bench aims at the following corner cases and the faults each one would expose:
- **Three-based way counts at every granularity, with offsets whose high bits are set.** A divider that drops a step or misaligns the remainder would give positions at or above the way count, or an upper offset off by one.
- **Way code 0.** A design that slices a zero-width field would report a non-zero position.
- **Illegal codes just past each legal range.** A decoder with a loose boundary would return a translated value instead of all ones.
- **A second `start` with changed inputs while busy, and input changes after `done`.** These would corrupt a design that reloads mid-division, or one that presents its outputs combinationally.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef struct packed {
    logic load;
    logic step;
    logic commitSlice;
    logic commitDiv;
    logic commitBad;
  } ilvStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_DIV, ST_COMMIT} ilvState_t;
  typedef enum logic [1:0] {MD_SLICE, MD_DIV, MD_BAD} ilvMode_t;

endpackage

// File: rtl/ilv_decode.sv
module ilv_decode #(
  parameter int EIW_W = 8,
  parameter int EIG_W = 16,
  parameter int POS_W = 4,
  parameter int MAX_EIG = 6
) (
  input  logic [EIW_W-1:0] eiw,
  input  logic [EIG_W-1:0] eig,
  output logic             valid,
  output logic             isDiv,
  output logic [POS_W:0]   ways
);
  logic wayOk;

  always_comb begin
    wayOk = 1'b1;
    ways  = '0;
    if (eiw <= EIW_W'(4)) begin
      ways = (POS_W+1)'(1) << eiw[2:0];
    end else if (eiw == EIW_W'(8)) begin
      ways = (POS_W+1)'(3);
    end else if (eiw == EIW_W'(9)) begin
      ways = (POS_W+1)'(6);
    end else if (eiw == EIW_W'(10)) begin
      ways = (POS_W+1)'(12);
    end else begin
      wayOk = 1'b0;
    end
    valid = wayOk && (eig <= EIG_W'(MAX_EIG));
    isDiv = eiw >= EIW_W'(8);
  end
endmodule

// File: rtl/ilv_ctrl.sv
module ilv_ctrl
  import ilv_pkg::*;
#(
  parameter int DIV_STEPS = 52
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       inValid,
  input  logic       inDiv,
  output ilvStrobe_t strb,
  output logic       busy,
  output logic       done
);
  localparam int CNT_W = $clog2(DIV_STEPS + 1);

  ilvState_t        state;
  ilvMode_t         mode;
  logic [CNT_W-1:0] stepCnt;
  logic             doneR;

  always_comb begin
    strb             = '0;
    strb.load        = (state == ST_IDLE) && start;
    strb.step        = (state == ST_DIV);
    strb.commitSlice = (state == ST_COMMIT) && (mode == MD_SLICE);
    strb.commitDiv   = (state == ST_COMMIT) && (mode == MD_DIV);
    strb.commitBad   = (state == ST_COMMIT) && (mode == MD_BAD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      mode    <= MD_SLICE;
      stepCnt <= '0;
      doneR   <= 1'b0;
    end else begin
      doneR <= strb.commitSlice || strb.commitDiv || strb.commitBad;
      case (state)
        ST_IDLE: if (start) begin
          stepCnt <= '0;
          if (!inValid) begin
            mode  <= MD_BAD;
            state <= ST_COMMIT;
          end else if (inDiv) begin
            mode  <= MD_DIV;
            state <= ST_DIV;
          end else begin
            mode  <= MD_SLICE;
            state <= ST_COMMIT;
          end
        end
        ST_DIV: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == CNT_W'(DIV_STEPS - 1)) state <= ST_COMMIT;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = doneR;

  // R9: done never lasts longer than one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10: a busy request runs to its own done, never restarts
  a_r10_busy_to_done: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));
  // R9: result is never reported while still busy
  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: rtl/ilv_datapath.sv
module ilv_datapath
  import ilv_pkg::*;
#(
  parameter int OFF_W    = 52,
  parameter int EIW_W    = 8,
  parameter int EIG_W    = 16,
  parameter int POS_W    = 4,
  parameter int LOW_BASE = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  ilvStrobe_t       strb,
  input  logic [OFF_W-1:0] hostIn,
  input  logic [EIW_W-1:0] eiwIn,
  input  logic [EIG_W-1:0] eigIn,
  input  logic [POS_W:0]   waysIn,
  output logic [POS_W-1:0] position,
  output logic [OFF_W-1:0] devOff,
  output logic             errFlag
);
  localparam int DIV_BASE = 8;

  function automatic logic [OFF_W-1:0] lowOnes(int n);
    if (n <= 0) return '0;
    if (n >= OFF_W) return '1;
    return (OFF_W'(1) << n) - OFF_W'(1);
  endfunction

  logic [OFF_W-1:0] hostR, divReg, quoR;
  logic [EIW_W-1:0] eiwR;
  logic [EIG_W-1:0] eigR;
  logic [POS_W:0]   waysR;
  logic [1:0]       remR;
  logic [POS_W-1:0] posR;
  logic [OFF_W-1:0] devR;
  logic             errR;

  int               gShift, sliceW, kAmt;
  logic [OFF_W-1:0] lowMask;
  logic [OFF_W-1:0] slicePosW, sliceDev, divPosW, divDev;
  logic [2:0]       trial;

  always_comb begin
    gShift    = int'(eigR) + LOW_BASE;
    sliceW    = (eiwR < EIW_W'(DIV_BASE)) ? int'(eiwR) : 0;
    kAmt      = (eiwR >= EIW_W'(DIV_BASE)) ? int'(eiwR) - DIV_BASE : 0;
    lowMask   = lowOnes(gShift);
    slicePosW = (hostR >> gShift) & lowOnes(sliceW);
    sliceDev  = ((hostR & ~lowOnes(gShift + sliceW)) >> sliceW) | (hostR & lowMask);
    divPosW   = (OFF_W'(remR) << kAmt) | ((hostR >> gShift) & lowOnes(kAmt));
    divDev    = (quoR << gShift) | (hostR & lowMask);
    trial     = {remR, divReg[OFF_W-1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      errR <= 1'b0;
      posR <= '0;
      devR <= '0;
      remR <= '0;
      quoR <= '0;
    end else begin
      if (strb.load) begin
        hostR  <= hostIn;
        eiwR   <= eiwIn;
        eigR   <= eigIn;
        waysR  <= waysIn;
        divReg <= hostIn >> (int'(eigIn) + int'(eiwIn));
        quoR   <= '0;
        remR   <= '0;
      end
      if (strb.step) begin
        divReg <= divReg << 1;
        if (trial >= 3'd3) begin
          remR <= 2'(trial - 3'd3);
          quoR <= {quoR[OFF_W-2:0], 1'b1};
        end else begin
          remR <= trial[1:0];
          quoR <= {quoR[OFF_W-2:0], 1'b0};
        end
      end
      if (strb.commitSlice) begin
        posR <= POS_W'(slicePosW);
        devR <= sliceDev;
        errR <= 1'b0;
      end
      if (strb.commitDiv) begin
        posR <= POS_W'(divPosW);
        devR <= divDev;
        errR <= 1'b0;
      end
      if (strb.commitBad) begin
        posR <= '1;
        devR <= '1;
        errR <= 1'b1;
      end
    end
  end

  assign position = posR;
  assign devOff   = devR;
  assign errFlag  = errR;

  // R2, R3: an illegal request leaves every result bit set
  a_r2_err_ones: assert property (@(posedge clk) disable iff (rst)
    errFlag |-> ((&devOff) && (&position)));
  // R4: low granule bits survive translation
  a_r4_low_pass: assert property (@(posedge clk) disable iff (rst)
    (strb.commitSlice || strb.commitDiv) |=> (((devOff ^ hostR) & lowMask) == '0));
  // R7: reported position is always below the way count
  a_r7_pos_range: assert property (@(posedge clk) disable iff (rst)
    (strb.commitSlice || strb.commitDiv) |=> ({1'b0, position} < waysR));
  // R11: results hold between commits
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !(strb.commitSlice || strb.commitDiv || strb.commitBad) |=> ($stable(devOff) && $stable(position)));
endmodule

// File: rtl/ilv_addr_decode.sv
module ilv_addr_decode
  import ilv_pkg::*;
#(
  parameter int OFF_W     = 52,
  parameter int EIW_W     = 8,
  parameter int EIG_W     = 16,
  parameter int POS_W     = 4,
  parameter int DIV_STEPS = OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [OFF_W-1:0] hostOff,
  input  logic [EIW_W-1:0] eiwCode,
  input  logic [EIG_W-1:0] eigCode,
  output logic             busy,
  output logic             done,
  output logic             errFlag,
  output logic [POS_W-1:0] position,
  output logic [OFF_W-1:0] devOff
);
  ilvStrobe_t     strb;
  logic           inValid, inDiv;
  logic [POS_W:0] inWays;

  ilv_decode #(.EIW_W(EIW_W), .EIG_W(EIG_W), .POS_W(POS_W)) u_decode (
    .eiw(eiwCode), .eig(eigCode), .valid(inValid), .isDiv(inDiv), .ways(inWays)
  );

  ilv_ctrl #(.DIV_STEPS(DIV_STEPS)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .inValid(inValid), .inDiv(inDiv),
    .strb(strb), .busy(busy), .done(done)
  );

  ilv_datapath #(.OFF_W(OFF_W), .EIW_W(EIW_W), .EIG_W(EIG_W), .POS_W(POS_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .hostIn(hostOff), .eiwIn(eiwCode),
    .eigIn(eigCode), .waysIn(inWays), .position(position), .devOff(devOff),
    .errFlag(errFlag)
  );

  // R1: reset leaves the block idle with no pending result
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!busy && !done && !errFlag));
endmodule

// File: tb/ilv_addr_decode_tb.sv
module ilv_addr_decode_tb;
  localparam int CLK_PERIOD = 10;
  localparam int OFF_W = 52;
  localparam int DIV_STEPS = 52;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [OFF_W-1:0] hostOff = '0;
  logic [7:0]       eiwCode = '0;
  logic [15:0]      eigCode = '0;
  logic             busy, done, errFlag;
  logic [3:0]       position;
  logic [OFF_W-1:0] devOff;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ilv_addr_decode u_dut (
    .clk(clk), .rst(rst), .start(start), .hostOff(hostOff), .eiwCode(eiwCode),
    .eigCode(eigCode), .busy(busy), .done(done), .errFlag(errFlag),
    .position(position), .devOff(devOff)
  );

  task automatic check(string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  function automatic longint unsigned ones(int n);
    if (n <= 0) return 0;
    if (n >= 64) return '1;
    return (64'd1 << n) - 64'd1;
  endfunction

  function automatic void refCalc(input longint unsigned h, input int w, input int g,
                                  output bit err, output longint unsigned pos,
                                  output longint unsigned dev);
    longint unsigned ways, low;
    err = 1'b0;
    if (w >= 0 && w <= 4) ways = 64'd1 << w;
    else if (w == 8) ways = 3;
    else if (w == 9) ways = 6;
    else if (w == 10) ways = 12;
    else begin ways = 0; err = 1'b1; end
    if (g < 0 || g > 6) err = 1'b1;
    if (err) begin pos = 64'hF; dev = ones(OFF_W); return; end
    low = h & ones(g + 8);
    if (w < 8) begin
      pos = (h >> (g + 8)) & ones(w);
      dev = ((h & ~ones(g + w + 8)) >> w) | low;
    end else begin
      pos = (h >> (g + 8)) % ways;
      dev = (((h >> (g + w)) / 3) << (g + 8)) | low;
    end
    dev = dev & ones(OFF_W);
  endfunction

  // runs one request; optional disturbance start pulse while busy (R10)
  task automatic runReq(longint unsigned h, int w, int g, bit disturb);
    bit err; longint unsigned ePos, eDev; int lat; int expLat;
    refCalc(h, w, g, err, ePos, eDev);
    expLat = (!err && w >= 8) ? 2 + DIV_STEPS : 2;
    @(negedge clk);
    hostOff = h[OFF_W-1:0]; eiwCode = 8'(w); eigCode = 16'(g); start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 1;
    while (!done && lat < 200) begin
      if (disturb && lat == 1 && busy) begin
        hostOff = ~h[OFF_W-1:0]; eiwCode = 8'd1; eigCode = 16'd0; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0; lat++;
    end
    check(disturb ? "R10 latency" : "R9 latency", lat, expLat);
    if (err) check("R2/R3 err", errFlag, 1);
    else check("R3 err clear", errFlag, 0);
    check(w >= 8 ? "R7 position" : "R5 position", position, ePos);
    check(w >= 8 ? "R8 devOff" : "R6 devOff", devOff, eDev);
    if (!err) check("R4 low bits", (devOff ^ h) & ones(g + 8), 0);
    @(negedge clk);
    check("R9 done pulse", done, 0);
    if (disturb) check("R10 no restart", busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    longint unsigned h; int w, g; logic [OFF_W-1:0] pHold, dHold;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 err", errFlag, 0);
    rst = 1'b0;

    h = 64'h000F_EDCB_A987_6543;
    runReq(h, 0, 0, 0);                     // R5: no interleave
    runReq(h, 4, 6, 0);
    runReq(h, 2, 3, 0);
    runReq(h, 8, 0, 0);                     // R7/R8 three ways
    runReq(64'h000F_FFFF_FFFF_FFFF, 10, 6, 0);
    runReq(64'h000F_FFFF_FFFF_FFFF, 9, 0, 0);
    runReq(h, 5, 0, 0);                     // R2 just past legal
    runReq(h, 11, 0, 0);
    runReq(h, 7, 2, 0);
    runReq(h, 1, 7, 0);                     // R3 just past legal
    runReq(h, 9, 3, 1);                     // R10 disturbance mid-divide
    runReq(h, 3, 1, 1);

    // R11: outputs hold while inputs wander without start
    pHold = OFF_W'(position); dHold = devOff;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      hostOff = OFF_W'({$urandom, $urandom}); eiwCode = 8'd2; eigCode = 16'd1;
    end
    check("R11 position hold", position, pHold[3:0]);
    check("R11 devOff hold", devOff, dHold);

    // R1: reset clears an error result
    runReq(h, 200, 0, 0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 err after reset", errFlag, 0);
    check("R1 busy after reset", busy, 0);

    for (int n = 0; n < 300; n++) begin
      h = {$urandom, $urandom} & ones(OFF_W);
      if ($urandom_range(99) < 85) begin
        case ($urandom_range(7))
          0: w = 0; 1: w = 1; 2: w = 2; 3: w = 3; 4: w = 4;
          5: w = 8; 6: w = 9; default: w = 10;
        endcase
      end else w = int'($urandom_range(255));
      g = ($urandom_range(99) < 90) ? int'($urandom_range(6)) : int'($urandom_range(65535));
      runReq(h, w, g, ($urandom_range(9) == 0));
    end
    finishRun();
  end
endmodule